// File: doc/BRIEF.md
# Mode-Configurable Synchronous Serial Shifter

This block moves one 8-bit frame at a time over a clocked serial link. It uses a single shift register. Its two data pads and its clock pad are re-routed by a small set of configuration inputs: master or slave role, single-wire (bidirectional) operation, a fixed-role mode, and separate transmit and receive enables. Software-facing logic writes a byte on the parallel write port. The block then shifts it out MSB first and shifts the incoming bits in at the same time. It returns the received byte on a read port together with a one-cycle done pulse.

As master, the block makes the serial clock from the system clock with a programmable even divisor and drives it on the clock pad. As slave, it passes the clock arriving on that pad through a synchronizer and acts on its edges. Each pad has its own output-enable so it can drive a tri-state pad cell. Configuration is captured when a frame starts, so changes made during a frame affect only the next one.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, busy, done and the read byte are all 0. With master selected, the clock pad is driven (output-enable 1) and sits high.
- R2: Standard master (bidirectional 0, fixed 0, master 1): transmit bits appear on pad A (pad_a_oe=1 when transmit is enabled), receive bits are taken from pad B, and pad_b_oe=0.
- R3: Standard slave (bidirectional 0, fixed 0, master 0): the roles swap. Transmit goes out on pad B (pad_b_oe=1 when transmit is enabled), receive comes from pad A, and pad_a_oe=0.
- R4: Bidirectional mode: transmit and receive both use pad A in either role. pad_b_oe stays 0 and the value on pad_b_i has no effect on the received byte.
- R5: In bidirectional mode only one direction runs per frame. With both enables set, transmit wins and the read byte is 0x00. With receive only, pad_a_oe is 0.
- R6: Fixed mode: transmit always uses pad A and receive always uses pad B, whatever the master/slave setting.
- R7: With master selected, the clock pad carries the generated clock, idles high and has output-enable 1. With slave selected, output-enable is 0 and the input clock is synchronized through two flops before use. That input clock must run at no more than a quarter of the system clock.
- R8: A frame is 8 bits, MSB first. The output bit changes on each falling serial-clock edge and the input bit is sampled on each rising edge.
- R9: The master serial-clock half period is cfg_div+1 system cycles, so the divisor is 2 to 256. done is seen 16*(cfg_div+1) clock edges after the edge that accepts the write.
- R10: busy rises on the edge that accepts a write and stays high until the end of the frame. At the end, done is high for exactly one cycle with busy low, and the read byte is updated. If receive is disabled (or suppressed by R5), the read byte is 0x00.
- R11: Configuration inputs changed while busy do not affect the frame in progress.
- R12: A write while busy is ignored: the frame in progress keeps transmitting its original byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = master (generates clock), 0 = slave |
| cfg_bidir | input | 1 | 1 = single-wire operation on pad A |
| cfg_fixed | input | 1 | 1 = fixed pad roles: transmit on A, receive on B |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_div | input | 7 | Master half period minus one, in system cycles |
| wr_en | input | 1 | Write strobe; starts a frame when idle |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Last received byte |
| done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | High during a frame |
| sck_i | input | 1 | Clock pad input (slave) |
| sck_o | output | 1 | Clock pad output value |
| sck_oe | output | 1 | Clock pad output enable |
| pad_a_i | input | 1 | Data pad A input |
| pad_a_o | output | 1 | Data pad A output value |
| pad_a_oe | output | 1 | Data pad A output enable |
| pad_b_i | input | 1 | Data pad B input |
| pad_b_o | output | 1 | Data pad B output value |
| pad_b_oe | output | 1 | Data pad B output enable |

## Verification
In master mode, the transmit bit is valid on the system edge that lowers the serial clock. The input bit is taken on the edge that raises it, and done plus the read byte follow on that same last rising edge. So done appears 16*(cfg_div+1) edges after the accepting write edge. The bench watches the clock pad on falling system edges, drives its peer bit right after each serial fall and checks the latency exactly. In slave mode, each bench clock edge reaches the shift logic on the third system edge after it changes. The bench therefore holds each serial-clock level for four system cycles and reads the transmit pad only after that, and it counts done pulses over a window rather than at one cycle.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    // Which data pad a direction is routed to
    typedef enum logic {
        PAD_A = 1'b0,
        PAD_B = 1'b1
    } pad_t;

    // Configuration captured at the start of each frame
    typedef struct packed {
        logic master;
        logic bidir;
        logic fixed;
        logic tx_en;
        logic rx_en;
    } mode_t;
endpackage

// File: rtl/ssp_clkgen.sv
// Master serial-clock generator.
// Produces a clock that idles high and toggles every HALF_M1+1 system
// cycles while run is high. It flags the system cycle of each toggle as a
// falling or rising event. Assumes run stays high until an even number of
// toggles has completed, so that the clock returns high.
module ssp_clkgen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_m1,
    output logic             sck_q,
    output logic             rise_ev,
    output logic             fall_ev
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick    = run && (cnt == half_m1);
    assign fall_ev = tick && sck_q;
    assign rise_ev = tick && !sck_q;

    // half-period counter, cleared while stopped and on every toggle
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (!run || tick)   cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    // serial clock register, held high while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)      sck_q <= 1'b1;
        else if (tick)   sck_q <= ~sck_q;
        else if (!run)   sck_q <= 1'b1;
    end

    // R7
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> sck_q);

    // R9
    half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(tick) && $past(cnt) != half_m1) |-> $stable(sck_q));
endmodule

// File: rtl/ssp_sync_edge.sv
// Synchronizer and edge detector for an external serial clock.
// The input goes through STAGES flops and one more flop for edge detection.
// The chain resets high to match the idle clock level. Assumes the input
// changes no faster than once every two system cycles.
module ssp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_ev,
    output logic fall_ev
);
    logic [STAGES:0] chain;

    // shift the external level through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], async_i};
    end

    assign rise_ev = chain[STAGES-1] && !chain[STAGES];
    assign fall_ev = !chain[STAGES-1] && chain[STAGES];

    // R7
    no_double_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_ev |=> !rise_ev);
endmodule

// File: rtl/ssp_pinmux.sv
// Pad router.
// Decides which data pad carries transmit and which carries receive, and
// which directions are active, from the frame configuration. Purely
// combinational. In single-wire mode transmit takes precedence over receive.
module ssp_pinmux
    import ssp_pkg::*;
(
    input  mode_t m,
    input  logic  out_bit,
    input  logic  pad_a_i,
    input  logic  pad_b_i,
    output logic  pad_a_o,
    output logic  pad_a_oe,
    output logic  pad_b_o,
    output logic  pad_b_oe,
    output logic  in_bit,
    output logic  tx_act,
    output logic  rx_act
);
    pad_t tx_pad, rx_pad;

    // route selection for each direction
    always_comb begin
        if (m.fixed) begin
            tx_pad = PAD_A;
            rx_pad = PAD_B;
        end else if (m.bidir) begin
            tx_pad = PAD_A;
            rx_pad = PAD_A;
        end else if (m.master) begin
            tx_pad = PAD_A;
            rx_pad = PAD_B;
        end else begin
            tx_pad = PAD_B;
            rx_pad = PAD_A;
        end
    end

    // active directions; single-wire forbids both at once
    always_comb begin
        tx_act = m.tx_en;
        rx_act = m.rx_en && !(m.bidir && !m.fixed && m.tx_en);
    end

    // pad drivers and received bit selection
    always_comb begin
        pad_a_o  = out_bit;
        pad_b_o  = out_bit;
        pad_a_oe = tx_act && (tx_pad == PAD_A);
        pad_b_oe = tx_act && (tx_pad == PAD_B);
        if (!rx_act)                in_bit = 1'b0;
        else if (rx_pad == PAD_A)   in_bit = pad_a_i;
        else                        in_bit = pad_b_i;
    end
endmodule

// File: rtl/sync_serial_port.sv
// Synchronous serial shifter, top level.
// Runs one FRAME_BITS frame per accepted write, MSB first. The output bit
// changes on falling serial-clock edges and input is sampled on rising
// edges. The serial clock comes from ssp_clkgen (master) or from the pad
// through ssp_sync_edge (slave). Configuration is latched at frame start.
// Assumes a slave clock of at most a quarter of the system clock.
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DIV_W       = 7,
    parameter int FRAME_BITS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_master,
    input  logic                  cfg_bidir,
    input  logic                  cfg_fixed,
    input  logic                  cfg_tx_en,
    input  logic                  cfg_rx_en,
    input  logic [DIV_W-1:0]      cfg_div,
    input  logic                  wr_en,
    input  logic [FRAME_BITS-1:0] wr_data,
    output logic [FRAME_BITS-1:0] rd_data,
    output logic                  done,
    output logic                  busy,
    input  logic                  sck_i,
    output logic                  sck_o,
    output logic                  sck_oe,
    input  logic                  pad_a_i,
    output logic                  pad_a_o,
    output logic                  pad_a_oe,
    input  logic                  pad_b_i,
    output logic                  pad_b_o,
    output logic                  pad_b_oe
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    mode_t                 mode_live, mode_q, mode_act;
    logic [DIV_W-1:0]      half_q;
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bitcnt;
    logic                  out_bit;
    logic                  start, run;
    logic                  gen_sck, gen_rise, gen_fall;
    logic                  ext_rise, ext_fall;
    logic                  rise_ev, fall_ev;
    logic                  in_bit, tx_act, rx_act;

    assign mode_live = '{master: cfg_master, bidir: cfg_bidir, fixed: cfg_fixed,
                         tx_en: cfg_tx_en, rx_en: cfg_rx_en};
    assign mode_act  = busy ? mode_q : mode_live;
    assign start     = wr_en && !busy;
    assign run       = busy && mode_q.master;

    ssp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .half_m1 (half_q),
        .sck_q   (gen_sck),
        .rise_ev (gen_rise),
        .fall_ev (gen_fall)
    );

    ssp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sck_i),
        .rise_ev (ext_rise),
        .fall_ev (ext_fall)
    );

    ssp_pinmux u_mux (
        .m        (mode_act),
        .out_bit  (out_bit),
        .pad_a_i  (pad_a_i),
        .pad_b_i  (pad_b_i),
        .pad_a_o  (pad_a_o),
        .pad_a_oe (pad_a_oe),
        .pad_b_o  (pad_b_o),
        .pad_b_oe (pad_b_oe),
        .in_bit   (in_bit),
        .tx_act   (tx_act),
        .rx_act   (rx_act)
    );

    // pick the edge source for the latched role; ignore edges while idle
    always_comb begin
        if (!busy) begin
            rise_ev = 1'b0;
            fall_ev = 1'b0;
        end else if (mode_q.master) begin
            rise_ev = gen_rise;
            fall_ev = gen_fall;
        end else begin
            rise_ev = ext_rise;
            fall_ev = ext_fall;
        end
    end

    // clock pad: generated clock when master, released when slave
    always_comb begin
        sck_oe = mode_act.master;
        sck_o  = mode_act.master ? gen_sck : 1'b1;
    end

    // frame sequencer: capture on write, shift on edges, finish on last rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            mode_q  <= '0;
            half_q  <= '0;
            shreg   <= '0;
            bitcnt  <= '0;
            out_bit <= 1'b1;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy   <= 1'b1;
                mode_q <= mode_live;
                half_q <= cfg_div;
                shreg  <= wr_data;
                bitcnt <= '0;
            end else if (busy) begin
                if (fall_ev) out_bit <= shreg[FRAME_BITS-1];
                if (rise_ev) begin
                    shreg  <= {shreg[FRAME_BITS-2:0], in_bit};
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == LAST_BIT) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        rd_data <= {shreg[FRAME_BITS-2:0], in_bit};
                        out_bit <= 1'b1;
                    end
                end
            end
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q));

    // R12
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && !rise_ev) |=> $stable(shreg));

    // R4
    bidir_padb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act.bidir && !mode_act.fixed) |-> !pad_b_oe);

    // R5
    bidir_one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act.bidir && !mode_act.fixed) |-> !(tx_act && rx_act));
endmodule

// File: tb/sim_sync_serial_port.sv
`timescale 1ns/1ps
module sim_sync_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b1, cfg_bidir = 1'b0, cfg_fixed = 1'b0;
    logic       cfg_tx_en = 1'b1, cfg_rx_en = 1'b1;
    logic [6:0] cfg_div = 7'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       done, busy;
    logic       sck_i = 1'b1;
    logic       sck_o, sck_oe;
    logic       pad_a_i = 1'b0, pad_b_i = 1'b0;
    logic       pad_a_o, pad_a_oe, pad_b_o, pad_b_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_seen = 0;
    int done_cyc = 0;

    sync_serial_port u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_master(cfg_master), .cfg_bidir(cfg_bidir), .cfg_fixed(cfg_fixed),
        .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en), .cfg_div(cfg_div),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .done(done), .busy(busy),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .pad_a_i(pad_a_i), .pad_a_o(pad_a_o), .pad_a_oe(pad_a_oe),
        .pad_b_i(pad_b_i), .pad_b_o(pad_b_o), .pad_b_oe(pad_b_oe)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (done) begin
            done_seen = done_seen + 1;
            done_cyc  = cyc;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // expected pad for transmit: 0 = pad A, 1 = pad B
    function automatic int tx_pad_of(bit m, bit b, bit f);
        return (f || b || m) ? 0 : 1;
    endfunction

    function automatic int rx_pad_of(bit m, bit b, bit f);
        if (f) return 1;
        if (b) return 0;
        return m ? 1 : 0;
    endfunction

    function automatic string tag_of(bit m, bit b, bit f, bit t, bit r);
        if (f) return "R6";
        if (b) return (t && r) ? "R5" : "R4";
        return m ? "R2" : "R3";
    endfunction

    task automatic drive_peer(input int rp, input bit v);
        if (rp == 0) begin pad_a_i = v;  pad_b_i = ~v; end
        else         begin pad_b_i = v;  pad_a_i = ~v; end
    endtask

    // one frame with the current configuration; bench acts as the peer
    task automatic run_frame(input logic [7:0] txb, input logic [7:0] peer, input bit flip);
        bit m = cfg_master, b = cfg_bidir, f = cfg_fixed, t = cfg_tx_en, r = cfg_rx_en;
        int h = int'(cfg_div) + 1;
        int tp = tx_pad_of(m, b, f);
        int rp = rx_pad_of(m, b, f);
        bit exp_rx = r && !(b && !f && t);
        string tg = tag_of(m, b, f, t, r);
        logic [7:0] got = 8'h00;
        logic [7:0] exp_rd;
        int d0, wcyc;
        exp_rd = exp_rx ? peer : 8'h00;
        d0 = done_seen;
        drive_peer(rp, peer[7]);
        @(negedge clk);
        wr_data = txb; wr_en = 1'b1; wcyc = cyc;
        @(negedge clk);
        wr_en = 1'b0;
        chk(busy == 1'b1, "R10", busy, 1);
        for (int i = 0; i < 8; i++) begin
            if (m) begin
                while (sck_o) @(negedge clk);
            end else begin
                sck_i = 1'b0;
                repeat (4) @(negedge clk);
            end
            drive_peer(rp, peer[7-i]);
            got[7-i] = (tp == 0) ? pad_a_o : pad_b_o;
            if (i == 0) begin
                chk(pad_a_oe == (t && tp == 0), tg, pad_a_oe, (t && tp == 0));
                chk(pad_b_oe == (t && tp == 1), tg, pad_b_oe, (t && tp == 1));
                chk(sck_oe == m, "R7", sck_oe, m);
            end
            if (flip && i == 3) begin
                cfg_master = ~m; cfg_bidir = ~b; cfg_tx_en = ~t; cfg_fixed = ~f;
                wr_data = ~txb; wr_en = 1'b1;
                @(negedge clk);
                wr_en = 1'b0;
                if (m) chk(sck_oe == 1'b1, "R11", sck_oe, 1);
            end
            if (m) begin
                while (!sck_o) @(negedge clk);
            end else begin
                sck_i = 1'b1;
                repeat (4) @(negedge clk);
            end
        end
        repeat (3) @(negedge clk);
        if (t) chk(got == txb, flip ? "R12" : "R8", got, txb);
        chk(rd_data == exp_rd, flip ? "R11" : (exp_rx ? "R8" : (b ? "R5" : "R10")), rd_data, exp_rd);
        chk(done_seen - d0 == 1, "R10", done_seen - d0, 1);
        chk(busy == 1'b0, "R10", busy, 0);
        if (m && !flip) chk(done_cyc - wcyc == 16*h + 1, "R9", done_cyc - wcyc, 16*h + 1);
        if (m) chk(sck_o == 1'b1, "R7", sck_o, 1);
        cfg_master = m; cfg_bidir = b; cfg_fixed = f; cfg_tx_en = t; cfg_rx_en = r;
    endtask

    task automatic set_mode(input bit m, input bit b, input bit f, input bit t, input bit r,
                            input logic [6:0] d);
        cfg_master = m; cfg_bidir = b; cfg_fixed = f; cfg_tx_en = t; cfg_rx_en = r; cfg_div = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", busy, 0);
        chk(done == 1'b0, "R1", done, 0);
        chk(rd_data == 8'h00, "R1", rd_data, 0);
        chk(sck_oe == 1'b1 && sck_o == 1'b1, "R1", {sck_oe, sck_o}, 2'b11);

        set_mode(1, 0, 0, 1, 1, 7'd0);  run_frame(8'hA5, 8'h3C, 0);  // R2
        set_mode(1, 0, 0, 1, 1, 7'd3);  run_frame(8'h81, 8'hC3, 0);  // R2, R9
        set_mode(0, 0, 0, 1, 1, 7'd0);  run_frame(8'h5A, 8'h96, 0);  // R3
        set_mode(1, 1, 0, 1, 0, 7'd1);  run_frame(8'hF0, 8'h0F, 0);  // R4 tx
        set_mode(0, 1, 0, 0, 1, 7'd0);  run_frame(8'h00, 8'hB7, 0);  // R4/R5 rx only
        set_mode(1, 1, 0, 1, 1, 7'd2);  run_frame(8'h69, 8'hFF, 0);  // R5 both
        set_mode(1, 0, 1, 1, 1, 7'd0);  run_frame(8'h12, 8'hED, 0);  // R6 master
        set_mode(0, 0, 1, 1, 1, 7'd0);  run_frame(8'h34, 8'hCB, 0);  // R6 slave
        set_mode(1, 0, 0, 0, 1, 7'd0);  run_frame(8'h00, 8'h55, 0);  // rx only
        set_mode(1, 0, 0, 1, 0, 7'd0);  run_frame(8'hC7, 8'hAA, 0);  // R10 rx off
        set_mode(1, 0, 0, 1, 1, 7'd127); run_frame(8'h7E, 8'h81, 0); // R9 max
        set_mode(1, 0, 0, 1, 1, 7'd2);  run_frame(8'hB4, 8'h2D, 1);  // R11, R12 master
        set_mode(0, 0, 0, 1, 1, 7'd0);  run_frame(8'h4B, 8'hD2, 1);  // R11, R12 slave

        for (int k = 0; k < 30; k++) begin
            set_mode($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                     $urandom_range(0, 1), $urandom_range(0, 1), 7'($urandom_range(0, 5)));
            run_frame(8'($urandom), 8'($urandom), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule